// File: doc/BRIEF.md
# Pipelined Radix-8 Significand Divider

This block divides one normalised significand by another and returns a fixed-width quotient that ends in a guard bit and a round bit. It also returns a sticky bit that tells whether the division left anything behind. Each compute step retires three quotient bits by repeated comparison against small multiples of the divisor. The steps are spread across a chain of pipeline registers, with two steps chained combinationally in each stage. The first stage spends one of its two slots on operand setup. The last stage's final step retires only the one or two bits left when the quotient width is not a multiple of three. Exponent handling, special operands, normalisation, rounding and packing belong to neighbouring blocks.

Operands enter on a valid/ready stream together with an opaque tag. Results leave on a second valid/ready stream in the same order, each with its tag. An input is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on a rising edge where `out_valid` and `out_ready` are both high. When `out_ready` is low, every occupied stage holds its contents, and `in_ready` falls once the first stage can no longer move. Bubbles are filled whenever the stage ahead is empty or moving, so with `out_ready` held high the block accepts one operation per cycle.

Top module: `mdiv_radix8_pipe`

## Requirements
- R1: Both operands must be normalised: bit SIG_W-1 (bit 23 by default) of `in_dividend` and of `in_divisor` is 1 whenever `in_valid` is high.
- R2: With default parameters, `out_quot` is 25 bits wide (FRAC_W plus guard and round). It equals floor(A * 2^24 / B), where A is the dividend and B is the divisor; in general the shift is Q_W-1. Bit 1 of `out_quot` is the guard bit and bit 0 is the round bit.
- R3: `out_sticky` is 1 exactly when A * 2^(Q_W-1) - `out_quot` * B is nonzero.
- R4: Each compute step retires DIGIT_W (3) quotient bits by taking the largest multiple 0..7 of B that does not exceed the shifted partial remainder. The final step retires only the leftover Q_W mod 3 bits (1 bit by default), so the low quotient bits are exact without padding. After every register stage the partial remainder is below B.
- R5: `out_hi` is 1 when A >= B. In that case `out_quot[Q_W-1]` is 1. Otherwise `out_quot[Q_W-1]` is 0 and `out_quot[Q_W-2]` is 1.
- R6: With the defaults there are 5 register stages (a setup stage holding one step, three stages of two steps, and a final stage of two steps). A result taken into an empty pipe shows `out_valid` at the sampling point after the 5th rising edge, counting the accepting edge as the 1st.
- R7: `out_tag` carries the tag given with the operands, unchanged, and results leave in the order the operands were accepted.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values on the next cycle. No accepted operation is lost or delivered twice. With `out_ready` held at 1, `in_ready` stays 1 and one operation is accepted every cycle.
- R9: While `rst_n` is 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_dividend | input | SIG_W (24) | Dividend significand, hidden 1 included |
| in_divisor | input | SIG_W (24) | Divisor significand, hidden 1 included |
| in_tag | input | TAG_W (4) | Opaque tag carried with the operation |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_quot | output | FRAC_W+2 (25) | Quotient, guard and round in the two low bits |
| out_sticky | output | 1 | Final remainder is nonzero |
| out_hi | output | 1 | Quotient's leading 1 is in the top bit (A >= B) |
| out_tag | output | TAG_W (4) | Tag of this result |

## Verification
Directed operand pairs sit at the edges of the quotient range. A = B gives an exact power of two. Largest over smallest pushes the quotient toward its maximum. Smallest over largest moves the leading 1 down one place. A just above B checks the guard and round bits and the sticky bit near a tie. Random normalised operands check the digit selection and the narrow last step, since a wrong multiple or a wrong shift shows up in the low bits. A random `out_ready` with gaps in `in_valid` exercises holding, bubble filling and ordering, which separates a stage that drops or repeats an entry from one that only stalls. A single operation sent into an empty pipe pins down the stage count.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

  // number of compute steps needed to retire qw quotient bits, db per step
  function automatic int unsigned step_count(int unsigned qw, int unsigned db);
    return (qw + db - 1) / db;
  endfunction

  // bits retired by step idx: full digit except a narrower final step
  function automatic int unsigned step_bits(int unsigned idx, int unsigned qw,
                                            int unsigned db);
    if (idx == step_count(qw, db) - 1) return qw - db * idx;
    return db;
  endfunction

  // left shift applied to the remainder before step idx; the first step
  // starts from the raw dividend, which may reach twice the divisor
  function automatic int unsigned step_shift(int unsigned idx, int unsigned qw,
                                             int unsigned db);
    if (idx == 0) return step_bits(idx, qw, db) - 1;
    return step_bits(idx, qw, db);
  endfunction

  // register stages: the first holds sps-1 steps, the rest up to sps each
  function automatic int unsigned stage_count(int unsigned qw, int unsigned db,
                                              int unsigned sps);
    int unsigned rest;
    rest = step_count(qw, db) - (sps - 1);
    return 1 + (rest + sps - 1) / sps;
  endfunction

  function automatic int unsigned stage_first(int unsigned s, int unsigned sps);
    if (s == 0) return 0;
    return (sps - 1) + (s - 1) * sps;
  endfunction

  function automatic int unsigned stage_len(int unsigned s, int unsigned qw,
                                            int unsigned db, int unsigned sps);
    int unsigned left;
    if (s == 0) return sps - 1;
    left = step_count(qw, db) - stage_first(s, sps);
    return (left < sps) ? left : sps;
  endfunction

endpackage

// File: rtl/mdiv_step.sv
module mdiv_step #(
  parameter int unsigned SIG_W = 24,
  parameter int unsigned REM_W = 27,
  parameter int unsigned Q_W   = 25,
  parameter int unsigned K     = 3,
  parameter int unsigned S     = 3
) (
  input  logic [REM_W-1:0] rem_i,
  input  logic [SIG_W-1:0] dvsr_i,
  input  logic [Q_W-1:0]   quot_i,
  output logic [REM_W-1:0] rem_o,
  output logic [Q_W-1:0]   quot_o
);
  localparam int unsigned N_MULT = (1 << K) - 1;

  logic [REM_W-1:0] shifted;
  logic [N_MULT:1]  fits;
  logic [K-1:0]     digit;
  logic [REM_W-1:0] taken;

  assign shifted = rem_i << S;

  // every candidate multiple compared in parallel; the ladder is monotonic,
  // so the count of fitting multiples is the selected digit
  for (genvar m = 1; m <= N_MULT; m++) begin : g_cmp
    assign fits[m] = shifted >= (REM_W'(m) * REM_W'(dvsr_i));
  end

  assign digit  = K'($countones(fits));
  assign taken  = REM_W'(digit) * REM_W'(dvsr_i);
  assign rem_o  = shifted - taken;
  assign quot_o = (quot_i << K) | Q_W'(digit);

endmodule

// File: rtl/mdiv_stage.sv
module mdiv_stage
  import mdiv_pkg::*;
#(
  parameter int unsigned SIG_W      = 24,
  parameter int unsigned REM_W      = 27,
  parameter int unsigned Q_W        = 25,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned DIGIT_W    = 3,
  parameter int unsigned FIRST_STEP = 0,
  parameter int unsigned N_STEPS    = 1,
  parameter bit          IS_SETUP   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [REM_W-1:0] up_rem,
  input  logic [Q_W-1:0]   up_quot,
  input  logic [SIG_W-1:0] up_dvsr,
  input  logic             up_hi,
  input  logic [TAG_W-1:0] up_tag,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [REM_W-1:0] dn_rem,
  output logic [Q_W-1:0]   dn_quot,
  output logic [SIG_W-1:0] dn_dvsr,
  output logic             dn_hi,
  output logic [TAG_W-1:0] dn_tag
);
  logic [REM_W-1:0] rem_c  [N_STEPS+1];
  logic [Q_W-1:0]   quot_c [N_STEPS+1];
  logic             hi_c;

  assign rem_c[0]  = up_rem;
  assign quot_c[0] = up_quot;

  // setup: the raw dividend decides where the quotient's leading 1 lands
  assign hi_c = IS_SETUP ? (up_rem >= REM_W'(up_dvsr)) : up_hi;

  for (genvar j = 0; j < N_STEPS; j++) begin : g_step
    mdiv_step #(
      .SIG_W (SIG_W),
      .REM_W (REM_W),
      .Q_W   (Q_W),
      .K     (step_bits(FIRST_STEP + j, Q_W, DIGIT_W)),
      .S     (step_shift(FIRST_STEP + j, Q_W, DIGIT_W))
    ) u_step (
      .rem_i  (rem_c[j]),
      .dvsr_i (up_dvsr),
      .quot_i (quot_c[j]),
      .rem_o  (rem_c[j+1]),
      .quot_o (quot_c[j+1])
    );
  end

  // a stage moves when it is empty or its contents leave this cycle
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        dn_valid <= 1'b0;
    else if (up_ready) dn_valid <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) begin
      dn_rem  <= rem_c[N_STEPS];
      dn_quot <= quot_c[N_STEPS];
      dn_dvsr <= up_dvsr;
      dn_hi   <= hi_c;
      dn_tag  <= up_tag;
    end
  end

  // R8: a stalled stage keeps its entry
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_quot) && $stable(dn_tag)
                              && $stable(dn_rem) && $stable(dn_hi));

  // R8: an accepted entry is never dropped
  p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);

  if (N_STEPS > 0) begin : g_rem_chk
    // R4: after any compute step the partial remainder is below the divisor
    p_rem_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_rem < REM_W'(dn_dvsr));
  end

endmodule

// File: rtl/mdiv_radix8_pipe.sv
module mdiv_radix8_pipe
  import mdiv_pkg::*;
#(
  parameter int unsigned SIG_W           = 24,
  parameter int unsigned FRAC_W          = 23,
  parameter int unsigned TAG_W           = 4,
  parameter int unsigned DIGIT_W         = 3,
  parameter int unsigned STEPS_PER_STAGE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SIG_W-1:0]    in_dividend,
  input  logic [SIG_W-1:0]    in_divisor,
  input  logic [TAG_W-1:0]    in_tag,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [FRAC_W+1:0]   out_quot,
  output logic                out_sticky,
  output logic                out_hi,
  output logic [TAG_W-1:0]    out_tag
);
  localparam int unsigned Q_W   = FRAC_W + 2;
  localparam int unsigned REM_W = SIG_W + DIGIT_W;
  localparam int unsigned N_STG = stage_count(Q_W, DIGIT_W, STEPS_PER_STAGE);

  logic             vld  [N_STG+1];
  logic             rdy  [N_STG+1];
  logic [REM_W-1:0] rem  [N_STG+1];
  logic [Q_W-1:0]   quot [N_STG+1];
  logic [SIG_W-1:0] dvsr [N_STG+1];
  logic             hi   [N_STG+1];
  logic [TAG_W-1:0] tag  [N_STG+1];

  assign vld[0]  = in_valid;
  assign rem[0]  = REM_W'(in_dividend);
  assign quot[0] = '0;
  assign dvsr[0] = in_divisor;
  assign hi[0]   = 1'b0;
  assign tag[0]  = in_tag;
  assign in_ready = rdy[0];
  assign rdy[N_STG] = out_ready;

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    mdiv_stage #(
      .SIG_W      (SIG_W),
      .REM_W      (REM_W),
      .Q_W        (Q_W),
      .TAG_W      (TAG_W),
      .DIGIT_W    (DIGIT_W),
      .FIRST_STEP (stage_first(s, STEPS_PER_STAGE)),
      .N_STEPS    (stage_len(s, Q_W, DIGIT_W, STEPS_PER_STAGE)),
      .IS_SETUP   (s == 0)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (vld[s]),
      .up_ready (rdy[s]),
      .up_rem   (rem[s]),
      .up_quot  (quot[s]),
      .up_dvsr  (dvsr[s]),
      .up_hi    (hi[s]),
      .up_tag   (tag[s]),
      .dn_valid (vld[s+1]),
      .dn_ready (rdy[s+1]),
      .dn_rem   (rem[s+1]),
      .dn_quot  (quot[s+1]),
      .dn_dvsr  (dvsr[s+1]),
      .dn_hi    (hi[s+1]),
      .dn_tag   (tag[s+1])
    );
  end

  // final extraction: whatever is left of the remainder forms the sticky bit
  assign out_valid  = vld[N_STG];
  assign out_quot   = quot[N_STG];
  assign out_sticky = |rem[N_STG];
  assign out_hi     = hi[N_STG];
  assign out_tag    = tag[N_STG];

  // R1: operands arrive normalised
  p_norm_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_dividend[SIG_W-1] && in_divisor[SIG_W-1]);

  // R5: leading 1 sits in the top bit or the one below, as the flag reports
  p_lead_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_quot[Q_W-1] == out_hi) && (out_quot[Q_W-1] || out_quot[Q_W-2]));

  // R9: nothing leaves the block in the cycle after reset
  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/mdiv_radix8_pipe_bench.sv
module mdiv_radix8_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SIG_W = 24;
  localparam int FRAC_W = 23;
  localparam int Q_W = FRAC_W + 2;
  localparam int TAG_W = 4;
  localparam int N_STG = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SIG_W-1:0] in_dividend = '0;
  logic [SIG_W-1:0] in_divisor = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [Q_W-1:0] out_quot;
  logic out_sticky;
  logic out_hi;
  logic [TAG_W-1:0] out_tag;

  mdiv_radix8_pipe u_mdiv_radix8_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_quot(out_quot),
    .out_sticky(out_sticky), .out_hi(out_hi), .out_tag(out_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [SIG_W-1:0] qa[$];
  logic [SIG_W-1:0] qb[$];
  logic [TAG_W-1:0] qt[$];
  int               qc[$];
  int cyc = 0;
  int pushed = 0;
  int popped = 0;
  logic [TAG_W-1:0] next_tag = '0;
  bit lat_probe = 1'b0;
  bit prev_stall = 1'b0;
  logic [Q_W-1:0] prev_quot;
  logic [TAG_W-1:0] prev_tag;
  logic prev_sticky;
  bit thru_fail = 1'b0;

  function automatic logic [Q_W-1:0] exp_quot(logic [SIG_W-1:0] a, logic [SIG_W-1:0] b);
    logic [63:0] n;
    n = 64'(a) << (Q_W - 1);
    return Q_W'(n / 64'(b));
  endfunction

  function automatic logic exp_sticky(logic [SIG_W-1:0] a, logic [SIG_W-1:0] b);
    logic [63:0] n;
    n = 64'(a) << (Q_W - 1);
    return (n % 64'(b)) != 0;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge: drive, sample before the rising edge, advance
  task automatic step(bit v, logic [SIG_W-1:0] a, logic [SIG_W-1:0] b, bit ordy);
    logic [SIG_W-1:0] ea, eb;
    logic [TAG_W-1:0] et;
    int ec;
    in_valid = v; in_dividend = a; in_divisor = b; in_tag = next_tag;
    out_ready = ordy;
    #1;
    if (prev_stall) begin
      // R8: stalled output holds
      check(out_valid && out_quot == prev_quot && out_tag == prev_tag &&
            out_sticky == prev_sticky, "R8", "stall hold quot",
            longint'(out_quot), longint'(prev_quot));
    end
    if (out_valid && out_ready) begin
      if (qa.size() == 0) begin
        check(1'b0, "R8", "result with nothing pending", longint'(out_tag), -1);
      end else begin
        ea = qa.pop_front(); eb = qb.pop_front(); et = qt.pop_front(); ec = qc.pop_front();
        popped++;
        check(out_quot == exp_quot(ea, eb), "R2 R4", "quotient",
              longint'(out_quot), longint'(exp_quot(ea, eb)));
        check(out_sticky == exp_sticky(ea, eb), "R3", "sticky",
              longint'(out_sticky), longint'(exp_sticky(ea, eb)));
        check(out_hi == (ea >= eb), "R5", "leading-one flag",
              longint'(out_hi), longint'(ea >= eb));
        check(out_tag == et, "R7", "tag order", longint'(out_tag), longint'(et));
        if (lat_probe) begin
          check(cyc - ec == N_STG, "R6", "latency cycles", cyc - ec, N_STG);
          lat_probe = 1'b0;
        end
      end
    end
    if (in_valid && in_ready) begin
      qa.push_back(a); qb.push_back(b); qt.push_back(next_tag); qc.push_back(cyc);
      pushed++;
      next_tag = next_tag + 1'b1;
    end
    prev_stall = out_valid && !out_ready;
    prev_quot = out_quot; prev_tag = out_tag; prev_sticky = out_sticky;
    cyc++;
    @(negedge clk);
  endtask

  function automatic logic [SIG_W-1:0] rnd_sig();
    return {1'b1, (SIG_W-1)'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: single operation into an empty pipe
    lat_probe = 1'b1;
    step(1'b1, 24'hC00000, 24'hA00000, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b0, '0, '0, 1'b1);
    check(!lat_probe, "R6", "latency probe completed", longint'(lat_probe), 0);

    // directed corners back to back, R8 full throughput
    begin
      logic [SIG_W-1:0] da [8];
      logic [SIG_W-1:0] db [8];
      da[0] = 24'h800000; db[0] = 24'h800000;
      da[1] = 24'hFFFFFF; db[1] = 24'h800000;
      da[2] = 24'h800000; db[2] = 24'hFFFFFF;
      da[3] = 24'hFFFFFF; db[3] = 24'hFFFFFF;
      da[4] = 24'h800001; db[4] = 24'h800000;
      da[5] = 24'h800000; db[5] = 24'h800001;
      da[6] = 24'hAAAAAA; db[6] = 24'hC00000;
      da[7] = 24'hFFFFFE; db[7] = 24'hFFFFFF;
      for (int i = 0; i < 8; i++) begin
        if (!in_ready) thru_fail = 1'b1;
        step(1'b1, da[i], db[i], 1'b1);
      end
      check(!thru_fail, "R8", "in_ready held with out_ready high", longint'(thru_fail), 0);
      for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 1'b1);
    end

    // random traffic with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, rnd_sig(), rnd_sig(), ($urandom % 3) != 0);
    end

    // drain
    for (int i = 0; i < 20; i++) step(1'b0, '0, '0, 1'b1);
    check(qa.size() == 0, "R8", "pending after drain", qa.size(), 0);
    check(pushed == popped, "R8", "results delivered", popped, pushed);
    check(out_valid == 1'b0, "R8", "out_valid after drain", longint'(out_valid), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule